// File: doc/BRIEF.md
# Single-Pin One-Wire Bus Slot Master

This block is the timing engine for a one-wire bus master. Each command it accepts runs one bus primitive and then stops. The four primitives are a write-one slot, a write-zero slot, a read slot, and a reset with presence detection. Byte assembly, device addressing, search and CRC are left to logic above it.

The bus is open-drain. The block only ever enables a low driver (`line_drive_low`) or lets an external pull-up raise the line. The line is observed through a two-flop synchronizer. Every timing value comes in on an input port in microseconds. It is counted in pulses of a one-cycle `us_tick` strobe that the chip supplies.

The read bit is decided by when the line rises after release. A rise before the valid-data limit means one. Otherwise the bit is zero, and polling gives up two microseconds past the limit. A reset first confirms that the idle line is high. It confirms again that the line is high after the presence window, and reports a wiring fault if either check sees the line low.

Top module: `ow_slot_master`

## Requirements
- R1: With opcode 2'b00 (write-one), the line is driven low for exactly `t_low1` ticks from acceptance, and `done` follows after `t_slot + t_rec` ticks of busy time.
- R2: With opcode 2'b01 (write-zero), the line is driven low for exactly `t_low0` ticks, and the operation holds busy for `t_slot + t_rec` ticks.
- R3: With opcode 2'b10 (read), the line is driven low for `t_lowr` ticks. If the released line is seen high while the elapsed time from slot start is below `t_rdv`, `read_bit` is 1.
- R4: In a read slot, a line first seen high at or after `t_rdv`, or never seen high by `t_rdv + 2`, gives `read_bit` 0. Either way the slot completes `t_slot` ticks after its start.
- R5: With opcode 2'b11 (reset), the line is driven low for `t_rstl` ticks. The line is sampled at `t_rstl + t_pdh + floor(t_pdl/2)`, and a low sample sets `presence` to 1. The operation completes at `t_rstl + t_rsth`.
- R6: If the line is low when a reset is accepted, the block never drives the line. It ends the operation within a few cycles with `fault`=1 and `presence`=0.
- R7: If the line is low when sampled at the end of a reset, the result is `fault`=1 and `presence`=0.
- R8: The line is driven low only during the low phase of a slot or reset. It is never driven low while idle.
- R9: A command is taken only while not busy. `cmd_valid` during an operation has no effect on its timing or result, and no second operation starts.
- R10: `done` is a one-cycle pulse with `busy` low in that cycle. `read_bit`, `presence` and `fault` update with `done` and hold until the next `done`. Write slots report all three as 0.
- R11: After reset, `busy`, `done`, `line_drive_low`, `read_bit`, `presence` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 write-one, 01 write-zero, 10 read, 11 reset |
| t_low1 | input | TW | Low time of a write-one slot |
| t_low0 | input | TW | Low time of a write-zero slot |
| t_lowr | input | TW | Low time opening a read slot |
| t_rdv | input | TW | Read valid-data limit from slot start |
| t_slot | input | TW | Slot length |
| t_rec | input | TW | Recovery time after a write slot |
| t_rstl | input | TW | Reset low time |
| t_pdh | input | TW | Delay before a presence pulse |
| t_pdl | input | TW | Presence pulse length |
| t_rsth | input | TW | Reset high window after release |
| line_in | input | 1 | Asynchronous bus line level |
| line_drive_low | output | 1 | 1 enables the low driver |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| read_bit | output | 1 | Bit from the last read slot |
| presence | output | 1 | A device answered the last reset |
| fault | output | 1 | Line found low outside a driven phase during reset |

## Verification
The bench attacks the read threshold from both sides. A device that releases a little before `t_rdv` must read as one. A device that releases just after it must read as zero, even though the release comes before polling stops. A design that compared against the polling limit instead of `t_rdv` would return one for the late release. A held-low device checks the timeout path; a design without it would hang or overrun the slot.

The reset cases cover three failure modes. A line shorted low before the reset must not be driven; a design that skips the pre-check would pulse the bus. A device that holds the line past the window must flag a fault instead of reporting presence. A missing device must report no presence, which catches a wrong sample point or an inverted sample.

A command injected mid-slot checks that busy gating is real; a design without it would restart its timer and stretch the slot.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

    typedef enum logic [1:0] {
        OP_WR1   = 2'b00,
        OP_WR0   = 2'b01,
        OP_READ  = 2'b10,
        OP_RESET = 2'b11
    } ow_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SLOT_LOW,
        ST_WR_WAIT,
        ST_RD_POLL,
        ST_RD_WAIT,
        ST_RST_CHECK,
        ST_RST_LOW,
        ST_RST_PD,
        ST_RST_END
    } ow_state_e;

    typedef struct packed {
        logic read_bit;
        logic presence;
        logic fault;
    } ow_result_t;

    // grace period past the valid-data limit before a read gives up
    localparam int POLL_GRACE_US = 2;

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] elapsed
);
    always_ff @(posedge clk) begin
        if (rst || clr)  elapsed <= '0;
        else if (tick)   elapsed <= elapsed + CW'(1);
    end

    // R1 R2 R5: elapsed time advances by one per tick during an operation
    tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> (elapsed == $past(elapsed) + CW'(1)));

    // R1: with no tick the count holds
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(elapsed));
endmodule

// File: rtl/ow_slot_master.sv
module ow_slot_master
    import ow_slot_pkg::*;
#(
    parameter int TW          = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          us_tick,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [TW-1:0] t_low1,
    input  logic [TW-1:0] t_low0,
    input  logic [TW-1:0] t_lowr,
    input  logic [TW-1:0] t_rdv,
    input  logic [TW-1:0] t_slot,
    input  logic [TW-1:0] t_rec,
    input  logic [TW-1:0] t_rstl,
    input  logic [TW-1:0] t_pdh,
    input  logic [TW-1:0] t_pdl,
    input  logic [TW-1:0] t_rsth,
    input  logic          line_in,
    output logic          line_drive_low,
    output logic          busy,
    output logic          done,
    output logic          read_bit,
    output logic          presence,
    output logic          fault
);
    localparam int CW = TW + 2;

    ow_state_e     state_q, state_d;
    ow_op_e        op_q;
    ow_result_t    res_q, res_d;
    ow_result_t    out_q;
    logic          pres_q, pres_d;
    logic          done_q, done_d;
    logic          line_s;
    logic [CW-1:0] elapsed;
    logic [CW-1:0] low_tgt, wr_end, pd_at, rst_end, rdv_lim;

    ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (line_in),
        .d_sync  (line_s)
    );

    ow_us_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (state_q == ST_IDLE),
        .tick    (us_tick),
        .elapsed (elapsed)
    );

    // all targets are measured from the start of the operation
    always_comb begin
        unique case (op_q)
            OP_WR1:  low_tgt = CW'(t_low1);
            OP_WR0:  low_tgt = CW'(t_low0);
            default: low_tgt = CW'(t_lowr);
        endcase
    end
    assign wr_end  = CW'(t_slot) + CW'(t_rec);
    assign pd_at   = CW'(t_rstl) + CW'(t_pdh) + CW'(t_pdl >> 1);
    assign rst_end = CW'(t_rstl) + CW'(t_rsth);
    assign rdv_lim = CW'(t_rdv) + CW'(POLL_GRACE_US);

    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        pres_d  = pres_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    res_d   = '0;
                    pres_d  = 1'b0;
                    state_d = (ow_op_e'(cmd_op) == OP_RESET) ? ST_RST_CHECK : ST_SLOT_LOW;
                end
            end
            ST_SLOT_LOW: begin
                if (elapsed >= low_tgt)
                    state_d = (op_q == OP_READ) ? ST_RD_POLL : ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (elapsed >= wr_end) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_RD_POLL: begin
                if (line_s) begin
                    res_d.read_bit = (elapsed < CW'(t_rdv));
                    state_d        = ST_RD_WAIT;
                end else if (elapsed >= rdv_lim) begin
                    res_d.read_bit = 1'b0;
                    state_d        = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (elapsed >= CW'(t_slot)) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            ST_RST_CHECK: begin
                if (!line_s) begin
                    res_d.fault = 1'b1;
                    state_d     = ST_IDLE;
                    done_d      = 1'b1;
                end else begin
                    state_d = ST_RST_LOW;
                end
            end
            ST_RST_LOW: begin
                if (elapsed >= CW'(t_rstl)) state_d = ST_RST_PD;
            end
            ST_RST_PD: begin
                if (elapsed >= pd_at) begin
                    pres_d  = !line_s;
                    state_d = ST_RST_END;
                end
            end
            ST_RST_END: begin
                if (elapsed >= rst_end) begin
                    res_d.fault    = !line_s;
                    res_d.presence = line_s ? pres_q : 1'b0;
                    state_d        = ST_IDLE;
                    done_d         = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_WR1;
            res_q   <= '0;
            out_q   <= '0;
            pres_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
            pres_q  <= pres_d;
            done_q  <= done_d;
            if (state_q == ST_IDLE && cmd_valid) op_q <= ow_op_e'(cmd_op);
            if (done_d) out_q <= res_d;
        end
    end

    assign line_drive_low = (state_q == ST_SLOT_LOW) || (state_q == ST_RST_LOW);
    assign busy           = (state_q != ST_IDLE);
    assign done           = done_q;
    assign read_bit       = out_q.read_bit;
    assign presence       = out_q.presence;
    assign fault          = out_q.fault;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_drive_low);

    // R6
    precheck_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RST_CHECK && !line_s) |=> (done && fault && !presence && !line_drive_low));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> (op_q == $past(op_q)));

    // R7
    fault_no_presence_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> !presence);
endmodule

// File: tb/ow_slot_master_tb.sv
module ow_slot_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW         = 10;
    localparam int TICK_DIV   = 8;

    localparam int LOW1 = 6,  LOW0 = 40, LOWR = 2, RDV = 10, SLOT = 60, REC = 2;
    localparam int RSTL = 48, PDH = 3,  PDL = 12, RSTH = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic dev_low = 1'b0;
    logic stuck = 1'b0;
    logic line_in;
    logic line_drive_low, busy, done, read_bit, presence, fault;

    int checks = 0;
    int errors = 0;

    assign line_in = !(line_drive_low || dev_low || stuck);

    always #(CLK_PERIOD/2) clk = ~clk;

    ow_slot_master #(.TW(TW)) dut_i (
        .clk(clk), .rst(rst), .us_tick(us_tick),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .t_low1(TW'(LOW1)), .t_low0(TW'(LOW0)), .t_lowr(TW'(LOWR)),
        .t_rdv(TW'(RDV)), .t_slot(TW'(SLOT)), .t_rec(TW'(REC)),
        .t_rstl(TW'(RSTL)), .t_pdh(TW'(PDH)), .t_pdl(TW'(PDL)),
        .t_rsth(TW'(RSTH)),
        .line_in(line_in), .line_drive_low(line_drive_low),
        .busy(busy), .done(done), .read_bit(read_bit),
        .presence(presence), .fault(fault)
    );

    // microsecond strobe, changed just after the rising edge
    initial begin
        int div = 0;
        forever begin
            @(posedge clk);
            #1;
            div = (div + 1) % TICK_DIV;
            us_tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // runs one operation; the device model pulls low starting dly ticks after
    // the block releases the line, for len ticks
    task automatic run_op(input logic [1:0] op, input int dly, input int len,
                          input bit stuck_v, input int inject,
                          output int low_t, output int busy_t, output int drv_seen,
                          output int post_busy, output logic rb, output logic pr,
                          output logic ft);
        bit prev = 1'b0;
        bit rel = 1'b0;
        int dcnt = 0;
        int iter = 0;
        low_t = 0; busy_t = 0; drv_seen = 0; post_busy = 0;
        rb = 1'b0; pr = 1'b0; ft = 1'b0;
        stuck = stuck_v;
        repeat (4) @(negedge clk);
        cmd_op = op;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (1) begin
            if (line_drive_low) drv_seen = 1;
            if (line_drive_low && us_tick) low_t++;
            if (busy && us_tick) busy_t++;
            if (prev && !line_drive_low && !rel) begin
                rel = 1'b1;
                dcnt = 0;
            end else if (rel && us_tick) begin
                dcnt++;
            end
            dev_low = rel && (dcnt >= dly) && (dcnt < dly + len);
            prev = line_drive_low;
            if (done) begin
                rb = read_bit; pr = presence; ft = fault;
                break;
            end
            if (iter == inject) begin
                cmd_valid = 1'b1;
                cmd_op = 2'b11;
            end else begin
                cmd_valid = 1'b0;
            end
            iter++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        dev_low = 1'b0;
        stuck = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (busy || line_drive_low) post_busy++;
        end
    endtask

    task automatic test_reset_state();
        chk(!busy && !done && !line_drive_low, "R11 idle after reset", busy, 0);
        chk(!read_bit && !presence && !fault, "R11 outputs cleared", {read_bit, presence, fault}, 0);
    endtask

    task automatic test_write(input bit one);
        int lt, bt, ds, pb;
        logic rb, pr, ft;
        run_op(one ? 2'b00 : 2'b01, 0, 0, 1'b0, -1, lt, bt, ds, pb, rb, pr, ft);
        if (one) chk(lt == LOW1, "R1 write-one low time", lt, LOW1);
        else     chk(lt == LOW0, "R2 write-zero low time", lt, LOW0);
        chk(bt == SLOT + REC, one ? "R1 write-one duration" : "R2 write-zero duration", bt, SLOT + REC);
        chk(!rb && !pr && !ft, "R10 write results zero", {rb, pr, ft}, 0);
        chk(pb == 0, "R8 released after write", pb, 0);
    endtask

    task automatic test_read(input int hold, input bit exp_bit, input string tag);
        int lt, bt, ds, pb;
        logic rb, pr, ft;
        int len;
        len = (hold > LOWR) ? hold - LOWR : 0;
        run_op(2'b10, 0, len, 1'b0, -1, lt, bt, ds, pb, rb, pr, ft);
        chk(lt == LOWR, {tag, " read low time"}, lt, LOWR);
        chk(rb == exp_bit, {tag, " read bit"}, rb, exp_bit);
        chk(bt == SLOT, "R4 read slot length", bt, SLOT);
    endtask

    task automatic test_reset_present(input bit dev);
        int lt, bt, ds, pb;
        logic rb, pr, ft;
        run_op(2'b11, PDH, dev ? PDL : 0, 1'b0, -1, lt, bt, ds, pb, rb, pr, ft);
        chk(lt == RSTL, "R5 reset low time", lt, RSTL);
        chk(bt == RSTL + RSTH, "R5 reset duration", bt, RSTL + RSTH);
        chk(pr == dev, "R5 presence", pr, dev);
        chk(!ft, "R5 no fault", ft, 0);
    endtask

    task automatic test_stuck_before();
        int lt, bt, ds, pb;
        logic rb, pr, ft;
        run_op(2'b11, 0, 0, 1'b1, -1, lt, bt, ds, pb, rb, pr, ft);
        chk(ds == 0, "R6 line never driven", ds, 0);
        chk(ft && !pr, "R6 fault reported", {ft, pr}, 2);
        chk(bt <= 1, "R6 immediate abort", bt, 0);
    endtask

    task automatic test_stuck_after();
        int lt, bt, ds, pb;
        logic rb, pr, ft;
        run_op(2'b11, PDH, 200, 1'b0, -1, lt, bt, ds, pb, rb, pr, ft);
        chk(ft == 1'b1, "R7 fault after window", ft, 1);
        chk(pr == 1'b0, "R7 presence cleared on fault", pr, 0);
    endtask

    task automatic test_busy_ignore();
        int lt, bt, ds, pb;
        logic rb, pr, ft;
        run_op(2'b01, 0, 0, 1'b0, 20, lt, bt, ds, pb, rb, pr, ft);
        chk(lt == LOW0, "R9 low time unchanged", lt, LOW0);
        chk(bt == SLOT + REC, "R9 duration unchanged", bt, SLOT + REC);
        chk(pb == 0, "R9 no second operation", pb, 0);
    endtask

    task automatic test_hold_outputs();
        int lt, bt, ds, pb;
        logic rb, pr, ft;
        run_op(2'b10, 0, 0, 1'b0, -1, lt, bt, ds, pb, rb, pr, ft);
        repeat (10) @(negedge clk);
        chk(read_bit == 1'b1, "R10 read bit held", read_bit, 1);
        chk(!done, "R10 done not repeated", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset_state();
        test_write(1'b1);
        test_write(1'b0);
        test_read(0,  1'b1, "R3 idle-high");
        test_read(6,  1'b1, "R3 early release");
        test_read(11, 1'b0, "R4 late release");
        test_read(30, 1'b0, "R4 timeout");
        test_reset_present(1'b1);
        test_reset_present(1'b0);
        test_stuck_before();
        test_stuck_after();
        test_busy_ignore();
        test_hold_outputs();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule